// File: doc/BRIEF.md
# Serial Audio Link Register Access Controller

This block sits on the controller side of a 13-slot serial audio codec link. On every bit clock it drives one outgoing frame bit and takes in one incoming frame bit. A frame is a 16-bit tag slot followed by twelve 20-bit slots, 256 bits in all. A host asks for a codec register read or write through a single request port. The block holds the request and waits for the next frame boundary. It then sends the command address slot, and for writes also the command data slot, in the next whole frame, and marks those slots valid in the outgoing tag.

On the receive side the block reads the incoming tag and captures the returned register address from the status address slot. It takes the returned register value from the status data slot. The value counts as updated only when it differs from the value already held, so a repeated read that returns the same value raises no flag. Every valid incoming slot from 3 to 12 goes out on one merged sample stream in slot order, together with its slot number. A status slot such as slot 12 therefore also lands in that stream, because no slot can be excluded.

The controller is a three-state machine. The states are ST_IDLE, ST_PENDING and ST_SENDING. The transitions are: ST_IDLE to ST_PENDING when a request is accepted; ST_PENDING to ST_SENDING on the last bit of a frame; ST_SENDING to ST_IDLE on the last bit of the command frame.

Top module: `ac97_regif`

## Requirements
- R1: Frames are 256 bits long: a 16-bit tag slot, then twelve 20-bit slots. `frame_sync` is high for exactly the 16 tag bits of every frame. Every bit is sent MSB first. Tag bit 15 (frame valid) is always sent as 1.
- R2: A frame that carries no command sends the tag 0x8000 and all-zero slots.
- R3: An accepted write is sent in the first whole frame after the one in which it was accepted. That frame carries the tag 0xE000, which has tag bits 15, 14 and 13 set (bits 14 and 13 mark slots 1 and 2 valid). Slot 1 holds the 7-bit address shifted left by 12, with bit 19 = 0. Slot 2 holds the 16-bit data shifted left by 4.
- R4: An accepted read is sent in the same frame position as a write. Its tag is 0xC000, slot 1 holds bit 19 = 1 together with the address shifted left by 12, and slot 2 is zero.
- R5: A write whose 8-bit request address exceeds 0x7F is discarded. `busy` stays low and no command appears in later frames.
- R6: `busy` goes high in the cycle after a request is accepted and stays high through the last bit of the command frame. A request made while `busy` is high has no effect.
- R7: When the incoming tag has bits 15 and 14 set, `rd_addr` takes slot 1 bits 18:12. When bits 15 and 13 are set, the slot 2 value bits 19:4 are a candidate for `rd_data`. Status slots that are not marked valid leave `rd_data` unchanged.
- R8: `stat_upd` pulses for one cycle, and `rd_data` changes, only when a valid slot 2 value differs from the held value. An equal value, including 0 after reset, gives no pulse.
- R9: Each incoming slot n from 3 to 12 whose tag bit (15-n) is set, with tag bit 15 also set, gives one `pcm_valid` pulse. The pulse carries `pcm_slot` = n and the whole 20-bit slot word. Pulses come in ascending slot order, and slot 12 is included. If tag bit 15 is clear, no slots are pushed.
- R10: During reset `busy`, `stat_upd` and `pcm_valid` are low, `rd_data` is 0, and `frame_sync` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Register address; bit 7 set makes a write invalid |
| req_wdata | input | 16 | Write value |
| busy | output | 1 | A request is held or being sent |
| rx_bit | input | 1 | Incoming frame bit |
| tx_bit | output | 1 | Outgoing frame bit |
| frame_sync | output | 1 | High during the tag slot |
| rd_data | output | 16 | Last distinct returned register value |
| rd_addr | output | 7 | Last returned register address |
| stat_upd | output | 1 | One-cycle pulse when rd_data changes |
| pcm_valid | output | 1 | Merged sample stream strobe |
| pcm_slot | output | 4 | Slot number of the pushed sample |
| pcm_data | output | 20 | Pushed slot word |

## Verification
Commands are tried with writes over walking-one addresses and the all-ones address, then with reads, then with writes whose address is 0x80 and 0xFF. Together these separate the read flag, the address field position, the data shift and the discard path. A second request made while the block is busy shows whether requests are blocked. The status path gets a sequence of 0, a new value, a repeat of that value, an invalid slot and a frame-invalid tag, which separates "captured" from "changed". The merged stream is swept over walking-one slot masks, the full mask, the empty mask and pseudo-random masks, each with its own data pattern. This exposes slot ordering, the tag bit mapping and the forced inclusion of slot 12.

// File: rtl/ac97_pkg.sv
package ac97_pkg;
    localparam int unsigned AC_TAG_W      = 16;
    localparam int unsigned AC_SLOT_W     = 20;
    localparam int unsigned AC_NUM_SLOTS  = 13;
    localparam int unsigned AC_ADDR_W     = 7;
    localparam int unsigned AC_DATA_W     = 16;
    localparam int unsigned AC_ADDR_SHIFT = 12;
    localparam int unsigned AC_DATA_SHIFT = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PENDING,
        ST_SENDING
    } link_state_e;
endpackage

// File: rtl/ac97_slot_timer.sv
module ac97_slot_timer #(
    parameter int unsigned TAG_W     = 16,
    parameter int unsigned SLOT_W    = 20,
    parameter int unsigned NUM_SLOTS = 13,
    localparam int unsigned SLOT_IDX_W = $clog2(NUM_SLOTS),
    localparam int unsigned BIT_IDX_W  = $clog2(SLOT_W)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    output logic [SLOT_IDX_W-1:0] slot_idx,
    output logic [BIT_IDX_W-1:0]  bit_idx,
    output logic                  slot_last,
    output logic                  frame_last
);
    assign slot_last  = (bit_idx == ((slot_idx == '0) ? BIT_IDX_W'(TAG_W - 1)
                                                      : BIT_IDX_W'(SLOT_W - 1)));
    assign frame_last = slot_last && (slot_idx == SLOT_IDX_W'(NUM_SLOTS - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_idx <= '0;
            bit_idx  <= '0;
        end else if (slot_last) begin
            bit_idx  <= '0;
            slot_idx <= frame_last ? '0 : slot_idx + 1'b1;
        end else begin
            bit_idx  <= bit_idx + 1'b1;
        end
    end
endmodule

// File: rtl/ac97_tx_framer.sv
module ac97_tx_framer #(
    parameter int unsigned TAG_W      = 16,
    parameter int unsigned SLOT_W     = 20,
    parameter int unsigned NUM_SLOTS  = 13,
    parameter int unsigned ADDR_W     = 7,
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned ADDR_SHIFT = 12,
    parameter int unsigned DATA_SHIFT = 4,
    localparam int unsigned SLOT_IDX_W = $clog2(NUM_SLOTS),
    localparam int unsigned BIT_IDX_W  = $clog2(SLOT_W)
) (
    input  logic [SLOT_IDX_W-1:0] slot_idx,
    input  logic [BIT_IDX_W-1:0]  bit_idx,
    input  logic                  cmd_active,
    input  logic                  cmd_write,
    input  logic [ADDR_W-1:0]     cmd_addr,
    input  logic [DATA_W-1:0]     cmd_data,
    output logic                  tx_bit
);
    logic [TAG_W-1:0]     tag_word;
    logic [SLOT_W-1:0]    slot_word;
    logic [BIT_IDX_W-1:0] bit_sel;

    always_comb begin
        tag_word            = '0;
        tag_word[TAG_W-1]   = 1'b1;
        tag_word[TAG_W-2]   = cmd_active;
        tag_word[TAG_W-3]   = cmd_active && cmd_write;
    end

    always_comb begin
        slot_word = '0;
        unique case (slot_idx)
            SLOT_IDX_W'(0): slot_word = SLOT_W'(tag_word) << (SLOT_W - TAG_W);
            SLOT_IDX_W'(1): begin
                if (cmd_active) begin
                    slot_word = SLOT_W'(cmd_addr) << ADDR_SHIFT;
                    slot_word[SLOT_W-1] = !cmd_write;
                end
            end
            SLOT_IDX_W'(2): begin
                if (cmd_active && cmd_write)
                    slot_word = SLOT_W'(cmd_data) << DATA_SHIFT;
            end
            default: slot_word = '0;
        endcase
    end

    assign bit_sel = BIT_IDX_W'(SLOT_W - 1) - bit_idx;
    assign tx_bit  = slot_word[bit_sel];
endmodule

// File: rtl/ac97_rx_gather.sv
module ac97_rx_gather #(
    parameter int unsigned TAG_W      = 16,
    parameter int unsigned SLOT_W     = 20,
    parameter int unsigned NUM_SLOTS  = 13,
    parameter int unsigned ADDR_W     = 7,
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned ADDR_SHIFT = 12,
    parameter int unsigned DATA_SHIFT = 4,
    localparam int unsigned SLOT_IDX_W = $clog2(NUM_SLOTS),
    localparam int unsigned TAG_IDX_W  = $clog2(TAG_W)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rx_bit,
    input  logic [SLOT_IDX_W-1:0] slot_idx,
    input  logic                  slot_last,
    output logic [DATA_W-1:0]     rd_data,
    output logic [ADDR_W-1:0]     rd_addr,
    output logic                  stat_upd,
    output logic                  pcm_valid,
    output logic [SLOT_IDX_W-1:0] pcm_slot,
    output logic [SLOT_W-1:0]     pcm_data
);
    logic [SLOT_W-1:0] shift_q;
    logic [SLOT_W-1:0] word;
    logic [TAG_W-1:0]  rx_tag;
    logic              slot_ok;

    assign word    = {shift_q[SLOT_W-2:0], rx_bit};
    assign slot_ok = rx_tag[TAG_W-1] &&
                     rx_tag[TAG_IDX_W'(TAG_W - 1) - TAG_IDX_W'(slot_idx)];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q   <= '0;
            rx_tag    <= '0;
            rd_data   <= '0;
            rd_addr   <= '0;
            stat_upd  <= 1'b0;
            pcm_valid <= 1'b0;
            pcm_slot  <= '0;
            pcm_data  <= '0;
        end else begin
            shift_q   <= word;
            stat_upd  <= 1'b0;
            pcm_valid <= 1'b0;
            if (slot_last) begin
                if (slot_idx == '0) begin
                    rx_tag <= word[TAG_W-1:0];
                end else if (slot_ok) begin
                    if (slot_idx == SLOT_IDX_W'(1)) begin
                        rd_addr <= word[ADDR_SHIFT +: ADDR_W];
                    end else if (slot_idx == SLOT_IDX_W'(2)) begin
                        if (word[DATA_SHIFT +: DATA_W] != rd_data) begin
                            rd_data  <= word[DATA_SHIFT +: DATA_W];
                            stat_upd <= 1'b1;
                        end
                    end else begin
                        pcm_valid <= 1'b1;
                        pcm_slot  <= slot_idx;
                        pcm_data  <= word;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/ac97_regif.sv
module ac97_regif
    import ac97_pkg::*;
#(
    parameter int unsigned TAG_W      = AC_TAG_W,
    parameter int unsigned SLOT_W     = AC_SLOT_W,
    parameter int unsigned NUM_SLOTS  = AC_NUM_SLOTS,
    parameter int unsigned ADDR_W     = AC_ADDR_W,
    parameter int unsigned DATA_W     = AC_DATA_W,
    parameter int unsigned ADDR_SHIFT = AC_ADDR_SHIFT,
    parameter int unsigned DATA_SHIFT = AC_DATA_SHIFT,
    localparam int unsigned SLOT_IDX_W = $clog2(NUM_SLOTS),
    localparam int unsigned BIT_IDX_W  = $clog2(SLOT_W)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [ADDR_W:0]       req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    output logic                  busy,
    input  logic                  rx_bit,
    output logic                  tx_bit,
    output logic                  frame_sync,
    output logic [DATA_W-1:0]     rd_data,
    output logic [ADDR_W-1:0]     rd_addr,
    output logic                  stat_upd,
    output logic                  pcm_valid,
    output logic [SLOT_IDX_W-1:0] pcm_slot,
    output logic [SLOT_W-1:0]     pcm_data
);
    link_state_e           state_q, state_d;
    logic [SLOT_IDX_W-1:0] slot_idx;
    logic [BIT_IDX_W-1:0]  bit_idx;
    logic                  slot_last, frame_last;
    logic                  accept, cmd_active;
    logic                  cmd_write_q;
    logic [ADDR_W-1:0]     cmd_addr_q;
    logic [DATA_W-1:0]     cmd_data_q;

    ac97_slot_timer #(
        .TAG_W(TAG_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .slot_idx(slot_idx), .bit_idx(bit_idx),
        .slot_last(slot_last), .frame_last(frame_last)
    );

    // out-of-range writes never leave ST_IDLE
    assign accept = req_valid && !(req_write && req_addr[ADDR_W]);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            cmd_write_q <= 1'b0;
            cmd_addr_q  <= '0;
            cmd_data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && accept) begin
                cmd_write_q <= req_write;
                cmd_addr_q  <= req_addr[ADDR_W-1:0];
                cmd_data_q  <= req_wdata;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (accept)     state_d = ST_PENDING;
            ST_PENDING: if (frame_last) state_d = ST_SENDING;
            ST_SENDING: if (frame_last) state_d = ST_IDLE;
            default:                    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy       = (state_q != ST_IDLE);
        cmd_active = (state_q == ST_SENDING);
        frame_sync = (slot_idx == '0);
    end

    ac97_tx_framer #(
        .TAG_W(TAG_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS),
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .ADDR_SHIFT(ADDR_SHIFT), .DATA_SHIFT(DATA_SHIFT)
    ) u_tx (
        .slot_idx(slot_idx), .bit_idx(bit_idx), .cmd_active(cmd_active),
        .cmd_write(cmd_write_q), .cmd_addr(cmd_addr_q), .cmd_data(cmd_data_q),
        .tx_bit(tx_bit)
    );

    ac97_rx_gather #(
        .TAG_W(TAG_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS),
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .ADDR_SHIFT(ADDR_SHIFT), .DATA_SHIFT(DATA_SHIFT)
    ) u_rx (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .slot_idx(slot_idx),
        .slot_last(slot_last), .rd_data(rd_data), .rd_addr(rd_addr),
        .stat_upd(stat_upd), .pcm_valid(pcm_valid), .pcm_slot(pcm_slot),
        .pcm_data(pcm_data)
    );
endmodule

// File: rtl/ac97_regif_checker.sv
module ac97_regif_checker #(
    parameter int unsigned NUM_SLOTS = 13,
    parameter int unsigned ADDR_W    = 7,
    parameter int unsigned DATA_W    = 16,
    localparam int unsigned SLOT_IDX_W = $clog2(NUM_SLOTS)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_valid,
    input logic                  req_write,
    input logic [ADDR_W:0]       req_addr,
    input logic                  busy,
    input logic                  tx_bit,
    input logic                  frame_sync,
    input logic [DATA_W-1:0]     rd_data,
    input logic                  stat_upd,
    input logic                  pcm_valid,
    input logic [SLOT_IDX_W-1:0] pcm_slot
);
    a_r1_tag_valid_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_sync) |-> tx_bit);

    a_r6_busy_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && !(req_write && req_addr[ADDR_W])) |=> busy);

    a_r5_discard_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && req_write && req_addr[ADDR_W]) |=> !busy);

    a_r8_upd_means_change: assert property (@(posedge clk) disable iff (!rst_n)
        stat_upd |-> (rd_data != $past(rd_data)));

    a_r8_change_means_upd: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data != $past(rd_data)) |-> stat_upd);

    a_r9_pcm_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
        pcm_valid |-> (pcm_slot >= SLOT_IDX_W'(3) &&
                       pcm_slot <= SLOT_IDX_W'(NUM_SLOTS - 1)));
endmodule

bind ac97_regif ac97_regif_checker #(
    .NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .busy(busy), .tx_bit(tx_bit), .frame_sync(frame_sync),
    .rd_data(rd_data), .stat_upd(stat_upd), .pcm_valid(pcm_valid),
    .pcm_slot(pcm_slot)
);

// File: tb/ac97_regif_bench.sv
module ac97_regif_bench;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n, req_valid, req_write, rx_bit;
    logic [7:0]  req_addr;
    logic [15:0] req_wdata, rd_data;
    logic        busy, tx_bit, frame_sync, stat_upd, pcm_valid;
    logic [6:0]  rd_addr;
    logic [3:0]  pcm_slot;
    logic [19:0] pcm_data;

    ac97_regif u_ac97_regif (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy),
        .rx_bit(rx_bit), .tx_bit(tx_bit), .frame_sync(frame_sync),
        .rd_data(rd_data), .rd_addr(rd_addr), .stat_upd(stat_upd),
        .pcm_valid(pcm_valid), .pcm_slot(pcm_slot), .pcm_data(pcm_data)
    );

    int errors = 0, checks = 0, sync_err = 0, n_upd = 0, n_log = 0;
    logic [19:0]  log_data [0:63];
    logic [3:0]   log_slot [0:63];
    logic [255:0] tx, idle_rx;
    logic         b0;

    task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [255:0] exp_tx(input logic act, input logic wr,
                                            input logic [6:0] a, input logic [15:0] d);
        logic [255:0] f = '0;
        f[255:240] = {1'b1, act, act & wr, 13'b0};
        if (act) f[239:220] = {~wr, a, 12'b0};
        if (act && wr) f[219:200] = {d, 4'b0};
        return f;
    endfunction

    function automatic logic [19:0] pcm_word(input logic [7:0] seed, input int n);
        return {seed, 4'(n), ~seed};
    endfunction

    function automatic logic [255:0] mk_rx(input logic fv, input logic v1, input logic [19:0] s1,
                                           input logic v2, input logic [19:0] s2,
                                           input logic [9:0] pm, input logic [7:0] seed);
        logic [255:0] f = '0;
        f[255] = fv; f[254] = v1; f[253] = v2;
        f[239:220] = s1; f[219:200] = s2;
        for (int n = 3; n < 13; n++) begin
            f[240 + 15 - n] = pm[n-3];
            f[239 - 20*(n-1) -: 20] = pcm_word(seed, n);
        end
        return f;
    endfunction

    // entered at the falling edge of frame bit 0, leaves at the next one
    task automatic run_frame(input logic [255:0] rxf, input int rp, input logic rwr,
                             input logic [7:0] ra, input logic [15:0] rd,
                             output logic [255:0] txf, output logic busy0);
        for (int i = 0; i < 256; i++) begin
            rx_bit = rxf[255-i];
            txf[255-i] = tx_bit;
            if (i == 0) busy0 = busy;
            if (frame_sync !== (i < 16)) sync_err++;
            if (pcm_valid === 1'b1 && n_log < 64) begin
                log_data[n_log] = pcm_data;
                log_slot[n_log] = pcm_slot;
                n_log++;
            end
            if (stat_upd === 1'b1) n_upd++;
            if (i == rp) begin
                req_valid = 1'b1; req_write = rwr; req_addr = ra; req_wdata = rd;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        #1_500_000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0]  waddr [0:8];
        logic [9:0]  mask;
        logic [15:0] lf;
        idle_rx = '0;
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
        req_addr = '0; req_wdata = '0; rx_bit = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        chk("R10 busy", busy, 0);
        chk("R10 rd_data", rd_data, 0);
        chk("R10 stat_upd", stat_upd, 0);
        chk("R10 pcm_valid", pcm_valid, 0);
        chk("R10 frame_sync", frame_sync, 1);
        rst_n = 1'b1;

        run_frame(idle_rx, -1, 0, 0, 0, tx, b0);
        chk("R2 idle frame", tx, exp_tx(0, 0, 0, 0));

        // R3: writes over walking-one and full addresses
        waddr[0] = 8'h26; waddr[8] = 8'h7F;
        for (int k = 0; k < 7; k++) waddr[k+1] = 8'(1 << k);
        for (int k = 0; k < 9; k++) begin
            logic [15:0] d = 16'hA5C3 ^ 16'(k * 16'h1111);
            run_frame(idle_rx, 100 + k, 1, waddr[k], d, tx, b0);
            chk("R2 frame before write", tx, exp_tx(0, 0, 0, 0));
            run_frame(idle_rx, -1, 0, 0, 0, tx, b0);
            chk("R3 write frame", tx, exp_tx(1, 1, waddr[k][6:0], d));
            chk("R6 busy in write frame", b0, 1);
            run_frame(idle_rx, -1, 0, 0, 0, tx, b0);
            chk("R6 idle after write", {b0, tx}, {1'b0, exp_tx(0, 0, 0, 0)});
        end

        // R5: discarded writes
        run_frame(idle_rx, 40, 1, 8'h80, 16'hFFFF, tx, b0);
        chk("R5 busy low 0x80", busy, 0);
        run_frame(idle_rx, 60, 1, 8'hFF, 16'h1234, tx, b0);
        chk("R5 no command", {b0, tx}, {1'b0, exp_tx(0, 0, 0, 0)});
        run_frame(idle_rx, -1, 0, 0, 0, tx, b0);
        chk("R5 no command later", {b0, tx}, {1'b0, exp_tx(0, 0, 0, 0)});

        // R4 read, R6 request while busy ignored
        run_frame(idle_rx, 10, 0, 8'h12, 16'h0, tx, b0);
        run_frame(idle_rx, 50, 1, 8'h33, 16'h1111, tx, b0);
        chk("R4 read frame", tx, exp_tx(1, 0, 7'h12, 0));
        run_frame(idle_rx, -1, 0, 0, 0, tx, b0);
        chk("R6 busy request ignored", {b0, tx}, {1'b0, exp_tx(0, 0, 0, 0)});
        run_frame(idle_rx, 20, 0, 8'h7F, 16'h0, tx, b0);
        run_frame(idle_rx, -1, 0, 0, 0, tx, b0);
        chk("R4 read 0x7F", tx, exp_tx(1, 0, 7'h7F, 0));

        // R7/R8: status capture
        n_upd = 0;
        run_frame(mk_rx(1, 1, {1'b0, 7'h12, 12'h0}, 1, 20'h0000F, 0, 0), -1, 0, 0, 0, tx, b0);
        chk("R7 rd_addr", rd_addr, 7'h12);
        chk("R8 zero equals reset", {n_upd, rd_data}, {32'd0, 16'h0});
        run_frame(mk_rx(1, 1, {1'b0, 7'h12, 12'h0}, 1, 20'h1234A, 0, 0), -1, 0, 0, 0, tx, b0);
        chk("R8 new value", {n_upd, rd_data}, {32'd1, 16'h1234});
        run_frame(mk_rx(1, 1, {1'b0, 7'h12, 12'h0}, 1, 20'h12345, 0, 0), -1, 0, 0, 0, tx, b0);
        chk("R8 repeat no flag", {n_upd, rd_data}, {32'd1, 16'h1234});
        run_frame(mk_rx(1, 1, {1'b0, 7'h44, 12'h0}, 0, 20'hBEEF0, 0, 0), -1, 0, 0, 0, tx, b0);
        chk("R7 invalid slot2 kept", {n_upd, rd_data, 9'(rd_addr)}, {32'd1, 16'h1234, 9'h44});
        run_frame(mk_rx(0, 1, {1'b0, 7'h55, 12'h0}, 1, 20'h55550, 0, 0), -1, 0, 0, 0, tx, b0);
        chk("R7 frame invalid kept", {n_upd, rd_data, 9'(rd_addr)}, {32'd1, 16'h1234, 9'h44});
        run_frame(mk_rx(1, 0, 20'h0, 1, 20'hBEEF0, 0, 0), -1, 0, 0, 0, tx, b0);
        chk("R8 second change", {n_upd, rd_data}, {32'd2, 16'hBEEF});

        // R9: merged stream sweep
        lf = 16'hACE1;
        for (int k = 0; k < 41; k++) begin
            int  e;
            logic bad;
            if (k < 10) mask = 10'(1 << k);
            else if (k == 10 || k == 40) mask = 10'h3FF;
            else if (k == 11) mask = 10'h000;
            else begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                mask = lf[9:0];
            end
            n_log = 0;
            run_frame(mk_rx(k != 40, 0, 0, 0, 0, mask, 8'(k * 7 + 3)), -1, 0, 0, 0, tx, b0);
            run_frame(idle_rx, -1, 0, 0, 0, tx, b0);
            e = 0; bad = 0;
            if (k != 40)
                for (int n = 3; n < 13; n++)
                    if (mask[n-3]) begin
                        if (e >= n_log || log_slot[e] !== 4'(n) ||
                            log_data[e] !== pcm_word(8'(k * 7 + 3), n)) bad = 1;
                        e++;
                    end
            chk("R9 push count", n_log, e);
            chk("R9 push order and data", bad, 0);
        end

        chk("R1 frame_sync tag span", sync_err, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule